// File: doc/BRIEF.md
# Impedance Sweep Mode Sequencer

This block is the control core of an impedance measurement front end. Software writes byte-wide registers that set a start frequency, a per-step frequency increment, a number of frequency points and a settling count. It then issues mode commands through a 16-bit control register. From these commands the sequencer drives the excitation engine. In the quiet mode both signal pins are tied to ground. A priming mode drives the excitation without taking any measurement. A sweep mode waits a programmed number of excitation-frequency periods at each point and then starts one measurement.

The excitation synthesizer, the analog output driver and the receive amplifiers are outside the block. The sequencer gives them a frequency word, an excitation enable, a pin-grounding control, an output-range select and a receive-gain select. An external measurement engine receives a one-cycle start pulse and answers with a one-cycle completion pulse. The sequencer then raises a data-valid flag and, after the last point, a sweep-complete flag.

Top module: `imp_sweep_seq`

## Requirements
- R1: After reset, mode is 0 (standby), sig_gnd is 1, exc_en is 0, meas_start, data_valid, sweep_done and cmd_err are 0, range_sel is 0 and rx_gain5 is 0.
- R2: Registers are written one byte at a time, with the most significant byte at the lowest address: start frequency at 0x82..0x84, increment at 0x85..0x87, point count at 0x88..0x89, settling count at 0x8A..0x8B. A write to 0x80 executes the command in data bits 7:4 (control bits D15:D12). A write to 0x81 changes no output.
- R3: Every write to 0x80 loads range_sel from data bits 2:1 (control D10:D9) and rx_gain5 from data bit 0 (control D8), including a write carrying the no-operation code 0x0.
- R4: The standby code 0xB is accepted in every mode. It returns mode to 0, sets sig_gnd to 1, clears exc_en, data_valid and sweep_done, and abandons any pending settle without a measurement.
- R5: The initialize code 0x1 is accepted only in standby. It sets mode 1 and exc_en 1, loads freq_word with the start frequency and never raises meas_start. In any other mode it is rejected with a one-cycle cmd_err and no state change.
- R6: The start-sweep code 0x2 is accepted in standby or initialize. It loads the start frequency, resets the point index and enters settle (mode 2). In any other mode it is rejected with a one-cycle cmd_err, and mode and freq_word stay unchanged.
- R7: In settle, exc_tick pulses are counted from zero. meas_start is a single-cycle pulse, raised one cycle after the count reaches the settling value (or one cycle after entering settle when that value is 0). Mode becomes 3 with it. Ticks outside settle are not counted.
- R8: meas_done in mode 3 sets data_valid. Mode goes to 5 with sweep_done set once the number of points measured at distinct frequencies reaches the point count (a count of 0 acts as 1). Otherwise mode goes to 4 (hold).
- R9: The increment code 0x3 is accepted only in hold. It adds the increment to freq_word and restarts settling. Elsewhere, sweep-complete included, it is rejected with cmd_err and freq_word unchanged.
- R10: The repeat code 0x4 is accepted in hold or sweep-complete. It keeps freq_word and restarts the settle count from zero.
- R11: Each accepted start-sweep, increment, repeat or standby command clears data_valid.
- R12: Control codes other than 0x0, 0x1, 0x2, 0x3, 0x4 and 0xB change neither mode nor freq_word and raise no cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write byte |
| exc_tick | input | 1 | One pulse per excitation output period |
| meas_done | input | 1 | Measurement engine completion pulse |
| mode | output | 3 | 0 standby, 1 initialize, 2 settle, 3 measure, 4 hold, 5 sweep complete |
| exc_en | output | 1 | Excitation output enable |
| sig_gnd | output | 1 | Ties the excitation and receive pins to ground |
| meas_start | output | 1 | One-cycle measurement trigger |
| freq_word | output | FREQ_W | Current excitation frequency word |
| range_sel | output | 2 | Output excitation range select |
| rx_gain5 | output | 1 | Receive gain select: 1 for x5, 0 for x1 |
| data_valid | output | 1 | Result of the current point is ready |
| sweep_done | output | 1 | All programmed points have been measured |
| cmd_err | output | 1 | One-cycle pulse on a rejected command |

## Verification
The sweep is driven with a nonzero settling count, with extra ticks arriving after the trigger, and with a zero settling count. This separates an exact period count from an early trigger, a late trigger or a trigger that keeps counting. Increment, repeat and a repeat after completion give three different frequency-word outcomes at each point. A scoreboard matches every trigger against the frequency and tick count expected at that moment. Commands given in the wrong mode and unknown codes are checked for cmd_err and for an unchanged mode and frequency word. A standby issued in the middle of settling confirms that no stray trigger follows.

// File: rtl/swp_pkg.sv
// Shared types and register addresses for the impedance sweep sequencer.
// Assumes byte-wide register writes on an 8-bit address space.
package swp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_INIT    = 3'd1,
        MD_SETTLE  = 3'd2,
        MD_MEASURE = 3'd3,
        MD_HOLD    = 3'd4,
        MD_DONE    = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_INIT,
        CMD_SWEEP,
        CMD_INCR,
        CMD_REPEAT,
        CMD_STANDBY
    } cmd_e;

    localparam logic [3:0] CODE_INIT    = 4'h1;
    localparam logic [3:0] CODE_SWEEP   = 4'h2;
    localparam logic [3:0] CODE_INCR    = 4'h3;
    localparam logic [3:0] CODE_REPEAT  = 4'h4;
    localparam logic [3:0] CODE_STANDBY = 4'hB;

    localparam logic [7:0] ADDR_CTRL   = 8'h80;
    localparam logic [7:0] ADDR_START  = 8'h82;
    localparam logic [7:0] ADDR_INCR   = 8'h85;
    localparam logic [7:0] ADDR_NPTS   = 8'h88;
    localparam logic [7:0] ADDR_SETTLE = 8'h8A;

endpackage

// File: rtl/swp_field.sv
// One multi-byte register written one byte at a time.
// The most significant byte sits at BASE, the following bytes at BASE+1 and up.
// Assumes W is at most 8 times the number of byte addresses reserved for it.
module swp_field #(
    parameter int         W    = 24,
    parameter logic [7:0] BASE = 8'h82
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [7:0]   wr_addr,
    input  logic [7:0]   wr_data,
    output wire  [W-1:0] value
);
    localparam int NB = (W + 7) / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int         LO   = b * 8;
        localparam int         HI   = (LO + 7 < W) ? LO + 7 : W - 1;
        localparam logic [7:0] ADDR = BASE + 8'(NB - 1 - b);

        logic [HI-LO:0] byte_q;

        // Capture this byte when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_en && wr_addr == ADDR)
                byte_q <= wr_data[HI-LO:0];
        end

        assign value[HI:LO] = byte_q;
    end
endmodule

// File: rtl/swp_regs.sv
// Parameter register bank: start frequency, increment, point count, settle count.
// Assumes the address windows in swp_pkg do not overlap for the chosen widths.
module swp_regs import swp_pkg::*; #(
    parameter int FREQ_W = 24,
    parameter int PTS_W  = 16,
    parameter int SETL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [FREQ_W-1:0] start_f,
    output logic [FREQ_W-1:0] inc_f,
    output logic [PTS_W-1:0]  npts,
    output logic [SETL_W-1:0] nsettle
);
    swp_field #(.W(FREQ_W), .BASE(ADDR_START)) u_start (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .value(start_f));

    swp_field #(.W(FREQ_W), .BASE(ADDR_INCR)) u_incr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .value(inc_f));

    swp_field #(.W(PTS_W), .BASE(ADDR_NPTS)) u_npts (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .value(npts));

    swp_field #(.W(SETL_W), .BASE(ADDR_SETTLE)) u_settle (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .value(nsettle));
endmodule

// File: rtl/swp_cmd_dec.sv
// Control register decoder. A write to the control address yields a one-cycle
// command strobe and latches the output-range and receive-gain selects.
// Assumes the command code sits in the top nibble of the control high byte.
module swp_cmd_dec import swp_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [3:0] cmd_nib,
    input  logic [2:0] sel_bits,
    output logic       cmd_vld,
    output cmd_e       cmd,
    output logic [1:0] range_sel,
    output logic       rx_gain5
);
    assign cmd_vld = wr_en && (wr_addr == ADDR_CTRL);

    // Map the raw code to a command; unknown codes become no-operation.
    always_comb begin
        case (cmd_nib)
            CODE_INIT:    cmd = CMD_INIT;
            CODE_SWEEP:   cmd = CMD_SWEEP;
            CODE_INCR:    cmd = CMD_INCR;
            CODE_REPEAT:  cmd = CMD_REPEAT;
            CODE_STANDBY: cmd = CMD_STANDBY;
            default:      cmd = CMD_NOP;
        endcase
    end

    // Latch the range and gain selects on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_sel <= 2'b00;
            rx_gain5  <= 1'b0;
        end else if (cmd_vld) begin
            range_sel <= sel_bits[2:1];
            rx_gain5  <= sel_bits[0];
        end
    end

    // R3
    sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> (range_sel == $past(sel_bits[2:1]) && rx_gain5 == $past(sel_bits[0])));
endmodule

// File: rtl/swp_settle.sv
// Settling counter: counts excitation periods while active and reports when
// the programmed count is reached. Restart clears it for a new point.
// Assumes one tick per excitation period, at most one per clock.
module swp_settle #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         reached
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    assign reached = active && (cnt_q >= limit);

    // Clear on a new point, otherwise count ticks until the limit is met.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (active && tick && !reached)
            cnt_q <= cnt_q + ONE;
    end

    // R7
    settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R7
    settle_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/imp_sweep_seq.sv
// Impedance sweep mode sequencer. Accepts control commands, steps the
// excitation frequency, gates each measurement by a settling count of
// excitation periods, and reports per-point and whole-sweep completion.
// Assumes meas_done arrives only after meas_start; a command written in the
// same cycle as a settle or measurement event takes priority over it.
module imp_sweep_seq import swp_pkg::*; #(
    parameter int FREQ_W = 24,
    parameter int PTS_W  = 16,
    parameter int SETL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              exc_tick,
    input  logic              meas_done,
    output logic [2:0]        mode,
    output logic              exc_en,
    output logic              sig_gnd,
    output logic              meas_start,
    output logic [FREQ_W-1:0] freq_word,
    output logic [1:0]        range_sel,
    output logic              rx_gain5,
    output logic              data_valid,
    output logic              sweep_done,
    output logic              cmd_err
);
    localparam logic [PTS_W:0] PT_ONE = {{PTS_W{1'b0}}, 1'b1};

    logic [FREQ_W-1:0] start_f, inc_f;
    logic [PTS_W-1:0]  npts;
    logic [SETL_W-1:0] nsettle;
    logic              cmd_vld;
    cmd_e              cmd;
    logic              reached;
    logic              restart;

    mode_e             mode_q, mode_n;
    logic [FREQ_W-1:0] freq_q, freq_n;
    logic [PTS_W-1:0]  idx_q, idx_n;
    logic              ms_q, ms_n;
    logic              dv_q, dv_n;
    logic              sd_q, sd_n;
    logic              err_q, err_n;
    logic [PTS_W:0]    pts_measured;
    logic              last_pt;

    swp_regs #(.FREQ_W(FREQ_W), .PTS_W(PTS_W), .SETL_W(SETL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_f(start_f), .inc_f(inc_f),
        .npts(npts), .nsettle(nsettle));

    swp_cmd_dec u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .cmd_nib(wr_data[7:4]), .sel_bits(wr_data[2:0]),
        .cmd_vld(cmd_vld), .cmd(cmd), .range_sel(range_sel), .rx_gain5(rx_gain5));

    swp_settle #(.W(SETL_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .active(mode_q == MD_SETTLE), .tick(exc_tick),
        .limit(nsettle), .reached(reached));

    assign pts_measured = {1'b0, idx_q} + PT_ONE;
    assign last_pt      = pts_measured >= {1'b0, npts};

    // Next-state logic: commands first, then settle and measurement events.
    always_comb begin
        mode_n  = mode_q;
        freq_n  = freq_q;
        idx_n   = idx_q;
        ms_n    = 1'b0;
        dv_n    = dv_q;
        sd_n    = sd_q;
        err_n   = 1'b0;
        restart = 1'b0;
        if (cmd_vld) begin
            case (cmd)
                CMD_STANDBY: begin
                    mode_n = MD_STANDBY;
                    dv_n   = 1'b0;
                    sd_n   = 1'b0;
                end
                CMD_INIT: begin
                    if (mode_q == MD_STANDBY) begin
                        mode_n = MD_INIT;
                        freq_n = start_f;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                CMD_SWEEP: begin
                    if (mode_q == MD_STANDBY || mode_q == MD_INIT) begin
                        mode_n  = MD_SETTLE;
                        freq_n  = start_f;
                        idx_n   = '0;
                        restart = 1'b1;
                        dv_n    = 1'b0;
                        sd_n    = 1'b0;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                CMD_INCR: begin
                    if (mode_q == MD_HOLD) begin
                        mode_n  = MD_SETTLE;
                        freq_n  = freq_q + inc_f;
                        idx_n   = pts_measured[PTS_W-1:0];
                        restart = 1'b1;
                        dv_n    = 1'b0;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                CMD_REPEAT: begin
                    if (mode_q == MD_HOLD || mode_q == MD_DONE) begin
                        mode_n  = MD_SETTLE;
                        restart = 1'b1;
                        dv_n    = 1'b0;
                        sd_n    = 1'b0;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                default: ;
            endcase
        end else begin
            case (mode_q)
                MD_SETTLE: begin
                    if (reached) begin
                        mode_n = MD_MEASURE;
                        ms_n   = 1'b1;
                    end
                end
                MD_MEASURE: begin
                    if (meas_done) begin
                        dv_n = 1'b1;
                        if (last_pt) begin
                            mode_n = MD_DONE;
                            sd_n   = 1'b1;
                        end else begin
                            mode_n = MD_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_STANDBY;
            freq_q <= '0;
            idx_q  <= '0;
            ms_q   <= 1'b0;
            dv_q   <= 1'b0;
            sd_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_n;
            freq_q <= freq_n;
            idx_q  <= idx_n;
            ms_q   <= ms_n;
            dv_q   <= dv_n;
            sd_q   <= sd_n;
            err_q  <= err_n;
        end
    end

    assign mode       = mode_q;
    assign sig_gnd    = (mode_q == MD_STANDBY);
    assign exc_en     = (mode_q != MD_STANDBY);
    assign meas_start = ms_q;
    assign freq_word  = freq_q;
    assign data_valid = dv_q;
    assign sweep_done = sd_q;
    assign cmd_err    = err_q;

    // R4
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_STANDBY) |=> (mode_q == MD_STANDBY && !dv_q && !sd_q && !ms_q));

    // R5
    init_nomeas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_INIT) |-> !ms_q);

    // R6
    sweep_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_SWEEP && mode_q != MD_STANDBY && mode_q != MD_INIT)
        |=> (err_q && $stable(mode_q) && $stable(freq_q)));

    // R7
    meas_from_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q |-> (mode_q == MD_MEASURE && $past(mode_q) == MD_SETTLE));

    // R7
    meas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q |=> !ms_q);

    // R8
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_q) |-> ($past(meas_done) && $past(mode_q) == MD_MEASURE));

    // R8
    done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q |-> (mode_q == MD_DONE));

    // R9
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(freq_q));
endmodule

// File: tb/sim_imp_sweep_seq.sv
// Scoreboard bench: the driver queues the expected frequency and tick count of
// each measurement trigger, and a monitor compares them when meas_start fires.
module sim_imp_sweep_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        exc_tick = 1'b0;
    logic        meas_done = 1'b0;
    logic [2:0]  mode;
    logic        exc_en, sig_gnd, meas_start, rx_gain5;
    logic        data_valid, sweep_done, cmd_err;
    logic [23:0] freq_word;
    logic [1:0]  range_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit armed = 1'b0;
    int tick_seen = 0;

    logic [23:0] q_freq[$];
    int          q_ticks[$];
    string       q_req[$];

    always #4 clk = ~clk;

    imp_sweep_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .exc_tick(exc_tick), .meas_done(meas_done),
        .mode(mode), .exc_en(exc_en), .sig_gnd(sig_gnd), .meas_start(meas_start),
        .freq_word(freq_word), .range_sel(range_sel), .rx_gain5(rx_gain5),
        .data_valid(data_valid), .sweep_done(sweep_done), .cmd_err(cmd_err));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic command(input logic [3:0] code, input logic [2:0] sel);
        wr(8'h80, {code, 1'b0, sel});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); exc_tick = 1'b1;
            @(negedge clk); exc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Queue the expected trigger, feed ticks, answer the measurement.
    task automatic point(input string req, input logic [23:0] f, input int n, input int extra);
        q_freq.push_back(f); q_ticks.push_back(n); q_req.push_back(req);
        ticks(n + extra);
        for (int i = 0; i < 50 && mode != 3'd3; i++) @(negedge clk);
        check(mode == 3'd3, "R7", "mode after trigger", mode, 3);
        @(negedge clk); meas_done = 1'b1;
        @(negedge clk); meas_done = 1'b0;
        check(data_valid == 1'b1, "R8", "data_valid after meas_done", data_valid, 1);
        check(meas_start == 1'b0, "R7", "meas_start single pulse", meas_start, 0);
    endtask

    // Count ticks the design can see since the last control write.
    always @(posedge clk) begin
        if (wr_en && wr_addr == 8'h80) begin
            tick_seen = 0;
            armed = 1'b1;
        end else if (armed && exc_tick) begin
            tick_seen++;
        end
    end

    // Monitor: compare each trigger against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && meas_start) begin
            if (q_freq.size() == 0) begin
                check(1'b0, "R7", "unexpected meas_start", 1, 0);
            end else begin
                logic [23:0] ef;
                int          et;
                string       rq;
                ef = q_freq.pop_front();
                et = q_ticks.pop_front();
                rq = q_req.pop_front();
                check(freq_word == ef, rq, "freq_word at trigger", freq_word, ef);
                check(tick_seen == et, "R7", "settle ticks before trigger", tick_seen, et);
            end
            armed = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(mode == 3'd0, "R1", "mode", mode, 0);
        check(sig_gnd && !exc_en, "R1", "pins grounded", {sig_gnd, exc_en}, 2'b10);
        check(!meas_start && !data_valid && !sweep_done && !cmd_err, "R1", "flags",
              {meas_start, data_valid, sweep_done, cmd_err}, 0);
        check(range_sel == 2'b00 && !rx_gain5, "R1", "selects", {range_sel, rx_gain5}, 0);

        // R2: the low control byte changes nothing
        wr(8'h81, 8'hFF);
        check(mode == 3'd0 && range_sel == 2'b00 && !rx_gain5 && !cmd_err, "R2",
              "write 0x81", {mode, range_sel, rx_gain5}, 0);

        // R3: no-operation code still loads range and gain
        command(4'h0, 3'b101);
        check(range_sel == 2'b10 && rx_gain5, "R3", "selects after nop", {range_sel, rx_gain5}, 3'b101);

        // R12: unknown code
        command(4'h7, 3'b011);
        check(!cmd_err && mode == 3'd0, "R12", "unknown code", {cmd_err, mode}, 0);
        check(range_sel == 2'b01 && rx_gain5, "R3", "selects after unknown", {range_sel, rx_gain5}, 3'b011);

        // R2 register programming
        wr(8'h82, 8'h12); wr(8'h83, 8'h34); wr(8'h84, 8'h56);
        wr(8'h85, 8'h00); wr(8'h86, 8'h01); wr(8'h87, 8'h00);
        wr(8'h88, 8'h00); wr(8'h89, 8'h03);
        wr(8'h8A, 8'h00); wr(8'h8B, 8'h04);

        // R9: increment rejected in standby
        command(4'h3, 3'b011);
        check(cmd_err && mode == 3'd0, "R9", "incr in standby", {cmd_err, mode}, 4'b1000);

        // R5: initialize excites at start frequency, never measures
        command(4'h1, 3'b011);
        check(mode == 3'd1 && exc_en && !sig_gnd, "R5", "init mode", {mode, exc_en, sig_gnd}, 5'b00110);
        check(freq_word == 24'h123456, "R2", "start frequency", freq_word, 24'h123456);
        ticks(6);
        check(mode == 3'd1, "R5", "still init after ticks", mode, 1);
        command(4'h1, 3'b011);
        check(cmd_err && mode == 3'd1, "R5", "init in init", {cmd_err, mode}, 4'b1001);

        // R6: start sweep from initialize
        command(4'h2, 3'b011);
        check(mode == 3'd2, "R6", "settle after start", mode, 2);
        point("R6", 24'h123456, 4, 2);
        check(mode == 3'd4 && !sweep_done, "R8", "hold after point 0", {mode, sweep_done}, 4'b1000);

        command(4'h2, 3'b011);
        check(cmd_err && mode == 3'd4 && freq_word == 24'h123456, "R6", "start in hold",
              {cmd_err, mode}, 4'b1100);

        // R9 / R11: increment
        command(4'h3, 3'b011);
        check(mode == 3'd2 && !data_valid, "R11", "incr clears valid", {mode, data_valid}, 4'b0100);
        check(freq_word == 24'h123556, "R9", "incremented frequency", freq_word, 24'h123556);
        point("R9", 24'h123556, 4, 1);

        // R10: repeat keeps frequency
        command(4'h4, 3'b011);
        check(freq_word == 24'h123556 && !data_valid, "R10", "repeat frequency", freq_word, 24'h123556);
        point("R10", 24'h123556, 4, 0);
        check(mode == 3'd4, "R8", "hold after repeat", mode, 4);

        command(4'h3, 3'b011);
        point("R9", 24'h123656, 4, 2);
        check(mode == 3'd5 && sweep_done, "R8", "sweep complete", {mode, sweep_done}, 4'b1011);

        command(4'h3, 3'b011);
        check(cmd_err && mode == 3'd5 && freq_word == 24'h123656, "R9", "incr when complete",
              {cmd_err, mode}, 4'b1101);

        command(4'h4, 3'b011);
        check(mode == 3'd2 && !sweep_done, "R10", "repeat when complete", {mode, sweep_done}, 4'b0100);
        point("R10", 24'h123656, 4, 0);
        check(mode == 3'd5 && sweep_done, "R8", "complete again", {mode, sweep_done}, 4'b1011);

        // R4 standby
        command(4'hB, 3'b011);
        check(mode == 3'd0 && sig_gnd && !exc_en, "R4", "standby pins", {mode, sig_gnd, exc_en}, 5'b00010);
        check(!data_valid && !sweep_done, "R4", "standby flags", {data_valid, sweep_done}, 0);

        // Zero settle, zero point count, start straight from standby
        wr(8'h82, 8'h00); wr(8'h83, 8'hAB); wr(8'h84, 8'hCD);
        wr(8'h88, 8'h00); wr(8'h89, 8'h00);
        wr(8'h8A, 8'h00); wr(8'h8B, 8'h00);
        command(4'h2, 3'b011);
        point("R6", 24'h00ABCD, 0, 0);
        check(mode == 3'd5 && sweep_done, "R8", "single point with count 0", {mode, sweep_done}, 4'b1011);

        // R4: standby in the middle of settling abandons the point
        command(4'hB, 3'b011);
        wr(8'h8B, 8'h05);
        command(4'h2, 3'b011);
        ticks(2);
        command(4'hB, 3'b011);
        ticks(6);
        check(mode == 3'd0 && !meas_start, "R4", "standby during settle", mode, 0);

        check(q_freq.size() == 0, "R7", "triggers left pending", q_freq.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule